// File: doc/BRIEF.md
# Supply and Watchdog Reset Sequencer

This block drives a single system reset line for a processor. It keeps reset active from power-up until a supply-good flag, produced by an external comparator, has stayed high for a fixed hold time. It re-asserts reset whenever that flag drops. Once the processor is running, a watchdog counts timebase ticks. The processor keeps the watchdog alive with bus traffic: a start condition followed by a stop condition, both reported as one-cycle strobes by the serial bus front end. If no such pair arrives within the selected period, the block issues a reset pulse of fixed length.

All durations are parameters counted in ticks of a timebase enable, so the same block serves millisecond-scale silicon timing and short simulation runs. A two-bit select chooses one of three timeout periods or turns the watchdog off. A parameter picks the polarity of the output.

Top module: `wdt_reset_sup`

## Requirements
- R1: While `por_n` is low, reset is active.
- R2: Reset is released only after `supply_ok` has been high on HOLD_TICKS consecutive tick cycles. A low cycle of `supply_ok` during the hold restarts the count from zero.
- R3: A cycle with `supply_ok` low makes reset active from the next clock edge, from any state.
- R4: Select code 2'b11 stops the watchdog and clears its count, so no watchdog reset occurs while it is applied. The period latched at power-up is 2'b11.
- R5: The watchdog period is TO_CODE0 ticks for code 2'b00, TO_CODE1 ticks for 2'b01, and TO_CODE2 ticks for 2'b10. The period is counted from the last restart or from the release of reset.
- R6: A watchdog timeout holds reset active for exactly PULSE_TICKS ticks. The watchdog count then starts again from zero.
- R7: A restart is a `bus_start` strobe followed later by a `bus_stop` strobe. A stop with no earlier start does not restart the watchdog, and neither does a start with no stop. A pending start is discarded when reset is active.
- R8: The select code is latched at each restart and at each release of reset. A change between these points does not alter the running period.
- R9: The hold, pulse and watchdog counters advance only on clock edges where `tick` is high.
- R10: With ACTIVE_HIGH = 1, `sys_rst` is high while reset is active. With ACTIVE_HIGH = 0, `sys_rst` is the complement of that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | Timebase enable, one cycle per tick |
| supply_ok | input | 1 | High while the supply is above the trip point |
| wd_sel | input | 2 | Watchdog period code; 2'b11 disables the watchdog |
| bus_start | input | 1 | One-cycle strobe on a bus start condition |
| bus_stop | input | 1 | One-cycle strobe on a bus stop condition |
| sys_rst | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The bench uses a hold of 6 ticks, a pulse of 4 ticks, and periods of 11, 7 and 5 ticks. With these values every watchdog period, pulse and hold window spans only a few dozen cycles. For each period code, the bench sweeps every restart offset from zero up to the timeout edge, and measures each interval to the exact cycle. A second instance, built with the opposite polarity, is compared against the first on every sampled cycle.

// File: rtl/wdt_reset_sup.sv
module wdt_reset_sup #(
  parameter int unsigned HOLD_TICKS  = 200,
  parameter int unsigned PULSE_TICKS = 200,
  parameter int unsigned TO_CODE0    = 1400,
  parameter int unsigned TO_CODE1    = 600,
  parameter int unsigned TO_CODE2    = 200,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic [1:0] wd_sel,
  input  logic       bus_start,
  input  logic       bus_stop,
  output logic       sys_rst
);

  localparam int unsigned MAX_A = (HOLD_TICKS > PULSE_TICKS) ? HOLD_TICKS : PULSE_TICKS;
  localparam int unsigned MAX_B = (TO_CODE0 > TO_CODE1) ? TO_CODE0 : TO_CODE1;
  localparam int unsigned MAX_C = (MAX_B > TO_CODE2) ? MAX_B : TO_CODE2;
  localparam int unsigned MAXT  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int unsigned CW    = $clog2(MAXT + 1);

  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

  typedef enum logic [1:0] {ST_HOLD, ST_PULSE, ST_RUN} st_t;

  st_t           st;
  logic [CW-1:0] seq_cnt, wd_cnt, wd_last;
  logic [1:0]    per;
  logic          armed;

  wire run     = (st == ST_RUN);
  wire restart = run && armed && bus_stop;
  wire wd_on   = run && (per != 2'b11) && (wd_sel != 2'b11);
  wire rst_act = !run;

  always_comb begin
    case (per)
      2'b00:   wd_last = CW'(TO_CODE0 - 1);
      2'b01:   wd_last = CW'(TO_CODE1 - 1);
      default: wd_last = CW'(TO_CODE2 - 1);
    endcase
  end

  assign sys_rst = ACTIVE_HIGH ? rst_act : !rst_act;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= ST_HOLD;
      seq_cnt <= '0;
      wd_cnt  <= '0;
      per     <= 2'b11;
      armed   <= 1'b0;
    end else if (!supply_ok) begin
      st      <= ST_HOLD;
      seq_cnt <= '0;
      wd_cnt  <= '0;
      armed   <= 1'b0;
    end else begin
      case (st)
        ST_HOLD, ST_PULSE: begin
          wd_cnt <= '0;
          armed  <= 1'b0;
          if (tick) begin
            if (seq_cnt == ((st == ST_HOLD) ? HOLD_LAST : PULSE_LAST)) begin
              st      <= ST_RUN;
              seq_cnt <= '0;
              per     <= wd_sel;
            end else begin
              seq_cnt <= seq_cnt + 1'b1;
            end
          end
        end
        default: begin
          if (bus_stop)       armed <= 1'b0;
          else if (bus_start) armed <= 1'b1;
          if (restart) begin
            wd_cnt <= '0;
            per    <= wd_sel;
          end else if (!wd_on) begin
            wd_cnt <= '0;
          end else if (tick) begin
            if (wd_cnt == wd_last) begin
              st      <= ST_PULSE;
              wd_cnt  <= '0;
              seq_cnt <= '0;
            end else begin
              wd_cnt <= wd_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!por_n) a_r1_por_active: assert (rst_act);
  end

  a_r3_low_supply: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rst_act);

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (run && supply_ok && wd_sel == 2'b11) |=> !rst_act);

  a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!por_n)
    (run && supply_ok && !tick) |=> !rst_act);

  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_act) |-> $past(supply_ok && tick));

endmodule

// File: tb/wdt_reset_sup_test.sv
`timescale 1ns/1ps
module wdt_reset_sup_test;
  localparam int HOLD = 6, PULSE = 4, T0 = 11, T1 = 7, T2 = 5;

  logic clk = 0, por_n = 0, tick = 1, supply_ok = 1, bus_start = 0, bus_stop = 0;
  logic [1:0] wd_sel = 2'b11;
  logic rst_hi, rst_lo;
  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  wdt_reset_sup #(.HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE), .TO_CODE0(T0),
    .TO_CODE1(T1), .TO_CODE2(T2), .ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok), .wd_sel(wd_sel),
    .bus_start(bus_start), .bus_stop(bus_stop), .sys_rst(rst_hi));

  wdt_reset_sup #(.HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE), .TO_CODE0(T0),
    .TO_CODE1(T1), .TO_CODE2(T2), .ACTIVE_HIGH(1'b0)) uut_lo (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok), .wd_sel(wd_sel),
    .bus_start(bus_start), .bus_stop(bus_stop), .sys_rst(rst_lo));

  function automatic int per_of(int s);
    return (s == 0) ? T0 : (s == 1) ? T1 : T2;
  endfunction

  task automatic chk(int act, int exp, string req);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(int'(rst_lo), int'(!rst_hi), "R10");
  endtask

  task automatic idle(int k, int lvl, string req);
    for (int i = 0; i < k; i++) begin
      step();
      chk(int'(rst_hi), lvl, req);
    end
  endtask

  task automatic measure(int lvl, int exp, string req);
    int n = 0;
    while (int'(rst_hi) == lvl && n < 100) begin
      n++;
      step();
    end
    chk(n, exp, req);
  endtask

  task automatic restart_after(int k);
    idle(k, 0, "R7");
    bus_start = 1; step(); chk(int'(rst_hi), 0, "R7");
    bus_start = 0; bus_stop = 1; step(); chk(int'(rst_hi), 0, "R7");
    bus_stop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3, 1, "R1");
    por_n = 1;
    measure(1, HOLD, "R2");
    idle(40, 0, "R4");
    wd_sel = 2'b00;
    idle(20, 0, "R8");
    restart_after(0);
    measure(0, T0, "R5");
    measure(1, PULSE, "R6");
    measure(0, T0, "R6");
    measure(1, PULSE, "R6");

    for (int s = 0; s < 3; s++) begin
      wd_sel = 2'(s);
      restart_after(0);
      measure(0, per_of(s), "R5");
      measure(1, PULSE, "R6");
      for (int k = 0; k <= per_of(s) - 2; k++) begin
        restart_after(k);
        measure(0, per_of(s), "R7");
        measure(1, PULSE, "R6");
      end
    end

    wd_sel = 2'b10;
    bus_stop = 1; step(); bus_stop = 0;
    measure(0, T2 - 1, "R7");
    measure(1, PULSE, "R6");
    bus_start = 1; step(); bus_start = 0;
    measure(0, T2 - 1, "R7");
    measure(1, PULSE, "R6");
    bus_stop = 1; step(); bus_stop = 0;
    measure(0, T2 - 1, "R7");
    measure(1, PULSE, "R6");

    restart_after(0);
    wd_sel = 2'b00;
    measure(0, T2, "R8");
    measure(1, PULSE, "R6");
    measure(0, T0, "R8");
    measure(1, PULSE, "R6");

    idle(6, 0, "R4");
    wd_sel = 2'b11;
    idle(10, 0, "R4");
    wd_sel = 2'b00;
    measure(0, T0, "R4");
    measure(1, PULSE, "R6");

    tick = 0;
    idle(30, 0, "R9");
    tick = 1;
    measure(0, T0, "R9");
    tick = 0;
    idle(10, 1, "R9");
    tick = 1;
    measure(1, PULSE, "R9");

    supply_ok = 0;
    idle(3, 1, "R3");
    supply_ok = 1;
    idle(3, 1, "R2");
    supply_ok = 0; step();
    supply_ok = 1;
    measure(1, HOLD, "R2");
    supply_ok = 0; step(); chk(int'(rst_hi), 1, "R3");
    supply_ok = 1; tick = 0;
    idle(10, 1, "R9");
    tick = 1;
    measure(1, HOLD, "R9");
    measure(0, T0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule